// File: doc/BRIEF.md
# Load/Store Lane Unit

This unit sits between a 32-bit core and a 32-bit data memory. For each access request it forms the effective address as the base register plus a sign-extended 16-bit offset, checks that the address suits the access size, and drives the memory-side signals. These signals are the address, the byte-lane enables, the write data laid out on the lanes, the write and I/O attributes, and an error flag for misalignment.

For stores, the low byte or low halfword of the source register is copied onto every lane of its size. The byte enables then pick which lanes the memory writes. When the memory returns a word for a load, the unit takes the addressed byte or halfword from that word. It then extends the value to 32 bits with either the sign bit or zeros, as the request asked. Lanes are little-endian: address bits [1:0] name the byte lane.

The request stage and the load-return stage each hold one register. A load response is decoded with the lane, size and signedness of the most recent load request.

Top module: `lsu_lane_unit`

## Requirements
- R1: One cycle after a request, `mem_addr_o` equals `req_base_i` plus `req_offset_i` sign-extended to 32 bits. For example, base 1260 with offset 80 gives 1340.
- R2: Size codes are 00 byte, 01 halfword, 10 word, and 11 (treated as word). A halfword with address bit 0 set is misaligned. A word with address bits [1:0] not 00 is misaligned. A misaligned access sets `misalign_o` and drives `mem_be_o` to 0000. A byte access is never misaligned.
- R3: On an aligned access, `mem_be_o` takes one of these values. A word gives 1111. A halfword gives 0011 when address bit 1 is 0 and 1100 when it is 1. A byte gives the single bit at position addr[1:0].
- R4: On a store, `mem_wdata_o` depends on the size. A byte store carries the source's bits [7:0] in all four lanes. A halfword store carries bits [15:0] in both halves. A word store carries the source unchanged. On a load, `mem_wdata_o` is zero.
- R5: `mem_valid_o` follows `req_valid_i` one cycle later. `mem_write_o` and `mem_io_o` repeat the request's store and I/O bits.
- R6: A byte load returns byte lane addr[1:0] of `rsp_rdata_i`. The value is sign-extended when `req_unsigned_i` was 0 and zero-extended when it was 1.
- R7: A halfword load returns the half chosen by address bit 1. The value is sign-extended when `req_unsigned_i` was 0 and zero-extended when it was 1.
- R8: A word load returns `rsp_rdata_i` unchanged. `ld_valid_o` follows `rsp_valid_i` one cycle later. The decode uses the attributes of the latest load request.
- R9: Synchronous reset clears `mem_valid_o`, `ld_valid_o`, `misalign_o`, `mem_addr_o` and `mem_be_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Access request present |
| req_store_i | input | 1 | 1 store, 0 load |
| req_size_i | input | 2 | Access size code |
| req_unsigned_i | input | 1 | Load zero-extends when 1 |
| req_io_i | input | 1 | I/O variant of the access |
| req_base_i | input | 32 | Base register value |
| req_offset_i | input | 16 | Signed byte offset |
| req_wdata_i | input | 32 | Store source register |
| mem_valid_o | output | 1 | Memory access issued |
| mem_write_o | output | 1 | Access is a store |
| mem_io_o | output | 1 | Access is an I/O variant |
| mem_addr_o | output | 32 | Effective address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| misalign_o | output | 1 | Size alignment error |
| rsp_valid_i | input | 1 | Load word returned |
| rsp_rdata_i | input | 32 | Returned memory word |
| ld_valid_o | output | 1 | Load result ready |
| ld_data_o | output | 32 | Extended load result |

## Verification
Every memory-side result (address, enables, data, attributes, misalign flag) is due exactly one clock edge after the request is driven. Each load result is due one edge after its response. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs against values its model produced for the previous drive. The model keeps its own copy of the latest load's lane, size and signedness. It updates that copy only after it has computed the load result for the current response, which matches the register order of the response stage.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 32;
    localparam int OFF_W_DEF  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      zext;
        logic      io;
        logic      store;
    } req_attr_t;

    function automatic acc_size_e norm_size(input logic [1:0] code);
        return (code == 2'b11) ? SZ_WORD : acc_size_e'(code);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int OFF_W  = OFF_W_DEF,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  acc_size_e         size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misalign_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        addr_o  = base_i + off_ext;
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE: misalign_o = 1'b0;
            SZ_HALF: misalign_o = addr_o[0];
            default: misalign_o = |addr_o[LANE_W-1:0];
        endcase
    end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  acc_size_e         size_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              misalign_i,
    input  logic              store_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] data_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit_byte;
        logic hit_half;
        logic [7:0] lane_byte;

        always_comb begin
            hit_byte = (lane_i == LANE_W'(i));
            hit_half = (lane_i[LANE_W-1:1] == (LANE_W-1)'(i / 2));
            unique case (size_i)
                SZ_BYTE: be_o[i] = hit_byte & ~misalign_i;
                SZ_HALF: be_o[i] = hit_half & ~misalign_i;
                default: be_o[i] = ~misalign_i;
            endcase
        end

        always_comb begin
            unique case (size_i)
                SZ_BYTE: lane_byte = src_i[7:0];
                SZ_HALF: lane_byte = src_i[8*(i%2) +: 8];
                default: lane_byte = src_i[8*i +: 8];
            endcase
            data_o[8*i +: 8] = store_i ? lane_byte : 8'h00;
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  acc_size_e         size_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              zext_i,
    output logic [DATA_W-1:0] data_o
);
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;
    logic [LANE_W-2:0] half_idx;

    always_comb begin
        half_idx = lane_i[LANE_W-1:1];
        sel_byte = rdata_i[8*lane_i +: 8];
        sel_half = rdata_i[16*half_idx +: 16];
        unique case (size_i)
            SZ_BYTE: data_o = {{(DATA_W-8){sel_byte[7] & ~zext_i}}, sel_byte};
            SZ_HALF: data_o = {{(DATA_W-16){sel_half[15] & ~zext_i}}, sel_half};
            default: data_o = rdata_i;
        endcase
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int OFF_W  = OFF_W_DEF,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_store_i,
    input  logic [1:0]        req_size_i,
    input  logic              req_unsigned_i,
    input  logic              req_io_i,
    input  logic [ADDR_W-1:0] req_base_i,
    input  logic [OFF_W-1:0]  req_offset_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              mem_valid_o,
    output logic              mem_write_o,
    output logic              mem_io_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LANES-1:0]  mem_be_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              misalign_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              ld_valid_o,
    output logic [DATA_W-1:0] ld_data_o
);
    req_attr_t         attr_c;
    logic [ADDR_W-1:0] addr_c;
    logic              mis_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wd_c;
    logic [DATA_W-1:0] ext_c;

    // attributes of the latest load, used to decode its returned word
    acc_size_e         ld_size_q;
    logic              ld_zext_q;
    logic [LANE_W-1:0] ld_lane_q;

    always_comb begin
        attr_c.size  = norm_size(req_size_i);
        attr_c.zext  = req_unsigned_i;
        attr_c.io    = req_io_i;
        attr_c.store = req_store_i;
    end

    lsu_agen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LANE_W (LANE_W)
    ) u_agen (
        .base_i     (req_base_i),
        .offset_i   (req_offset_i),
        .size_i     (attr_c.size),
        .addr_o     (addr_c),
        .misalign_o (mis_c)
    );

    lsu_store_steer #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_steer (
        .size_i     (attr_c.size),
        .lane_i     (addr_c[LANE_W-1:0]),
        .misalign_i (mis_c),
        .store_i    (attr_c.store),
        .src_i      (req_wdata_i),
        .be_o       (be_c),
        .data_o     (wd_c)
    );

    lsu_load_extract #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_extract (
        .rdata_i (rsp_rdata_i),
        .size_i  (ld_size_q),
        .lane_i  (ld_lane_q),
        .zext_i  (ld_zext_q),
        .data_o  (ext_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid_o <= 1'b0;
            mem_write_o <= 1'b0;
            mem_io_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_be_o    <= '0;
            mem_wdata_o <= '0;
            misalign_o  <= 1'b0;
            ld_size_q   <= SZ_WORD;
            ld_zext_q   <= 1'b0;
            ld_lane_q   <= '0;
        end else begin
            mem_valid_o <= req_valid_i;
            misalign_o  <= req_valid_i & mis_c;
            if (req_valid_i) begin
                mem_write_o <= attr_c.store;
                mem_io_o    <= attr_c.io;
                mem_addr_o  <= addr_c;
                mem_be_o    <= be_c;
                mem_wdata_o <= wd_c;
                if (!attr_c.store) begin
                    ld_size_q <= attr_c.size;
                    ld_zext_q <= attr_c.zext;
                    ld_lane_q <= addr_c[LANE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid_o <= 1'b0;
            ld_data_o  <= '0;
        end else begin
            ld_valid_o <= rsp_valid_i;
            if (rsp_valid_i) begin
                ld_data_o <= ext_c;
            end
        end
    end

    // R1: address is base plus sign-extended offset of the previous cycle
    a_r1_addr_sum: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o |-> mem_addr_o == $past(req_base_i)
            + {{(ADDR_W-OFF_W){$past(req_offset_i[OFF_W-1])}}, $past(req_offset_i)});

    // R2: misaligned accesses carry no enables
    a_r2_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (mem_valid_o && mem_be_o == '0));

    // R2: byte accesses never flag misalignment
    a_r2_byte_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_valid_o && $past(req_size_i) == 2'b00) |-> !misalign_o);

    // R3: aligned accesses enable one, two or all lanes
    a_r3_be_shape: assert property (@(posedge clk) disable iff (rst)
        (mem_valid_o && !misalign_o) |->
            ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
             || $countones(mem_be_o) == LANES));

    // R3: byte access enables exactly one lane
    a_r3_byte_single: assert property (@(posedge clk) disable iff (rst)
        (mem_valid_o && $past(req_size_i) == 2'b00) |-> $countones(mem_be_o) == 1);

    // R4: loads carry no write data
    a_r4_load_no_data: assert property (@(posedge clk) disable iff (rst)
        (mem_valid_o && !mem_write_o) |-> mem_wdata_o == '0);

    // R5: request valid appears on the memory side one cycle later with its attributes
    a_r5_valid_follow: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> (mem_valid_o && mem_io_o == $past(req_io_i)
                         && mem_write_o == $past(req_store_i)));

    // R8: load result follows its response by one cycle
    a_r8_ld_follow: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_i |=> ld_valid_o);

endmodule

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i, req_store_i, req_unsigned_i, req_io_i;
    logic [1:0]  req_size_i;
    logic [31:0] req_base_i, req_wdata_i;
    logic [15:0] req_offset_i;
    logic        mem_valid_o, mem_write_o, mem_io_o, misalign_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic        rsp_valid_i;
    logic [31:0] rsp_rdata_i;
    logic        ld_valid_o;
    logic [31:0] ld_data_o;

    always #2.5 clk = ~clk;

    lsu_lane_unit i_lsu_lane_unit (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_store_i(req_store_i),
        .req_size_i(req_size_i), .req_unsigned_i(req_unsigned_i),
        .req_io_i(req_io_i), .req_base_i(req_base_i),
        .req_offset_i(req_offset_i), .req_wdata_i(req_wdata_i),
        .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o),
        .mem_io_o(mem_io_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .misalign_o(misalign_o),
        .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
        .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // model expectations for the next compare point
    logic        e_mv = 0, e_wr = 0, e_io = 0, e_mis = 0, e_lv = 0;
    logic [31:0] e_addr = 0, e_wd = 0, e_ld = 0;
    logic [3:0]  e_be = 0;
    string       e_ld_tag = "R8";
    // model copy of the latest load's attributes
    int          h_size = 2;
    logic        h_uns = 0;
    int          h_lane = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            summary();
        end
    end

    function automatic logic [31:0] model_load(input logic [31:0] rd, input int sz,
                                               input logic uns, input int lane);
        logic [31:0] sh;
        if (sz == 0) begin
            sh = rd >> (8 * lane);
            return uns ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
        end else if (sz == 1) begin
            sh = rd >> (16 * (lane / 2));
            return uns ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
        end
        return rd;
    endfunction

    task automatic compare();
        chk("R5 mem_valid", {31'h0, mem_valid_o}, {31'h0, e_mv});
        if (e_mv) begin
            chk("R1 address", mem_addr_o, e_addr);
            chk("R2 misalign", {31'h0, misalign_o}, {31'h0, e_mis});
            chk("R3 byte enables", {28'h0, mem_be_o}, {28'h0, e_be});
            chk("R4 write data", mem_wdata_o, e_wd);
            chk("R5 write/io", {30'h0, mem_write_o, mem_io_o}, {30'h0, e_wr, e_io});
        end
        chk("R8 ld_valid", {31'h0, ld_valid_o}, {31'h0, e_lv});
        if (e_lv) chk(e_ld_tag, ld_data_o, e_ld);
    endtask

    task automatic cyc(input logic v, input logic st, input int sz, input logic uns,
                       input logic io, input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] wd, input logic rv, input logic [31:0] rd);
        int nsz;
        logic [31:0] a;
        @(negedge clk);
        compare();
        nsz = (sz == 3) ? 2 : sz;
        a = base + {{16{off[15]}}, off};
        e_mv = v;
        if (v) begin
            e_addr = a;
            e_wr = st;
            e_io = io;
            e_mis = (nsz == 1) ? a[0] : (nsz == 2) ? (a[1:0] != 2'b00) : 1'b0;
            if (e_mis) e_be = 4'b0000;
            else if (nsz == 0) e_be = 4'b0001 << a[1:0];
            else if (nsz == 1) e_be = a[1] ? 4'b1100 : 4'b0011;
            else e_be = 4'b1111;
            if (!st) e_wd = 32'h0;
            else if (nsz == 0) e_wd = {4{wd[7:0]}};
            else if (nsz == 1) e_wd = {2{wd[15:0]}};
            else e_wd = wd;
        end
        e_lv = rv;
        if (rv) begin
            e_ld = model_load(rd, h_size, h_uns, h_lane);
            e_ld_tag = (h_size == 0) ? "R6 byte load" : (h_size == 1) ? "R7 half load" : "R8 word load";
        end
        if (v && !st) begin
            h_size = nsz;
            h_uns = uns;
            h_lane = int'(a[1:0]);
        end
        req_valid_i = v; req_store_i = st; req_size_i = sz[1:0];
        req_unsigned_i = uns; req_io_i = io; req_base_i = base;
        req_offset_i = off; req_wdata_i = wd; rsp_valid_i = rv; rsp_rdata_i = rd;
    endtask

    task automatic idle(input logic rv, input logic [31:0] rd);
        cyc(0, 0, 0, 0, 0, 32'h0, 16'h0, 32'h0, rv, rd);
    endtask

    initial begin
        rst = 1'b1;
        req_valid_i = 0; req_store_i = 0; req_size_i = 0; req_unsigned_i = 0;
        req_io_i = 0; req_base_i = 0; req_offset_i = 0; req_wdata_i = 0;
        rsp_valid_i = 0; rsp_rdata_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 reset mem_valid", {31'h0, mem_valid_o}, 32'h0);
        chk("R9 reset ld_valid", {31'h0, ld_valid_o}, 32'h0);
        chk("R9 reset misalign", {31'h0, misalign_o}, 32'h0);
        chk("R9 reset addr", mem_addr_o, 32'h0);
        chk("R9 reset be", {28'h0, mem_be_o}, 32'h0);
        rst = 1'b0;

        // R1: worked example 1260 + 80 = 1340, word load then its response (R8)
        cyc(1, 0, 2, 0, 0, 32'd1260, 16'd80, 32'h0, 0, 0);
        idle(1, 32'h89AB_CDEF);
        // R1: negative offset, word store with I/O flag (R4, R5)
        cyc(1, 1, 2, 0, 1, 32'h0000_1000, 16'hFFFC, 32'h1122_3344, 0, 0);
        // R3/R4: byte stores on each lane, halfword stores on each half
        for (int l = 0; l < 4; l++)
            cyc(1, 1, 0, 0, l[0], 32'h2000 + l, 16'h0, 32'hA5A5_5AC3, 0, 0);
        cyc(1, 1, 1, 0, 0, 32'h3000, 16'h0, 32'hDEAD_BEEF, 0, 0);
        cyc(1, 1, 1, 0, 1, 32'h3000, 16'h2, 32'hDEAD_BEEF, 0, 0);
        // R2: misaligned halfword and word, reserved size as word
        cyc(1, 1, 1, 0, 0, 32'h4001, 16'h0, 32'h1234_5678, 0, 0);
        cyc(1, 0, 2, 0, 0, 32'h4002, 16'h0, 32'h0, 0, 0);
        cyc(1, 1, 3, 0, 0, 32'h4004, 16'h0, 32'hCAFE_F00D, 0, 0);
        cyc(1, 0, 3, 0, 0, 32'h4003, 16'h0, 32'h0, 0, 0);
        // R6: byte loads every lane, signed and unsigned
        for (int l = 0; l < 4; l++)
            for (int u = 0; u < 2; u++) begin
                cyc(1, 0, 0, u[0], 0, 32'h5000, 16'(l), 32'h0, 0, 0);
                idle(1, 32'h80F1_7F82);
            end
        // R7: halfword loads both halves, signed and unsigned
        for (int h = 0; h < 2; h++)
            for (int u = 0; u < 2; u++) begin
                cyc(1, 0, 1, u[0], 1, 32'h6000, 16'(2 * h), 32'h0, 0, 0);
                idle(1, 32'h8001_F123);
            end
        // mixed random traffic
        for (int n = 0; n < 600; n++)
            cyc(1'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom), 1'($urandom),
                $urandom, 16'($urandom), $urandom, 1'($urandom), $urandom);
        idle(0, 0);
        idle(0, 0);
        summary();
    end

endmodule